// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by fetching entries from a two-level page table in memory. It fetches each entry through a simple memory port: it raises a request with an address and then waits for a response strobe. A request also carries these qualifiers: whether the access is a write, the current privilege level, a supervisor-override flag, a write-protect enable and a large-page enable. The walker checks the access rights of each entry as it fetches it, and it ends every walk with a one-cycle completion pulse.

A walk that succeeds returns the physical address. A walk that fails raises a fault strobe, captures the linear address in a fault-address register and reports a three-bit fault code. A probe request runs the same checks but never raises a fault. A failed probe returns an all-ones physical address. The walker does not cache translations, does not modify table entries and does not deliver exceptions; those jobs belong to the surrounding logic.

Top module: `pgwalk_top`

## Requirements
- R1: The first fetch of a walk reads byte address `{dir_base[31:12], 12'b0} | (va[31:22] << 2)`.
- R2: A directory entry with bit 0 (present) clear ends the walk after that single fetch. The walk then fails with fault-code bit 0 = 0.
- R3: If the directory entry is present, has bit 7 set and large pages are enabled, the walk ends after one fetch. The physical address is then `{pde[31:22], va[21:0]}`. When large pages are disabled, bit 7 is ignored and the walker fetches the second level.
- R4: The second fetch reads byte address `{pde[31:12], 12'b0} | (va[21:12] << 2)`.
- R5: A successful small-page walk returns `{pte[31:12], va[11:0]}`.
- R6: A table entry with bit 0 clear fails with fault-code bit 0 = 0. For a small page, the permission bits are the bitwise AND of the directory entry and the table entry (bit 1 writable, bit 2 user).
- R7: When the privilege level is 3, the override is low and the effective user bit is 0, the access is denied. The override suppresses this check.
- R8: A write to a page whose effective writable bit is 0 is denied only when the override is low and either the privilege level is 3 or write-protect is enabled.
- R9: When a fault is raised, the fault code holds bit 0 = the page was present (the fault was a rights violation), bit 1 = the access was a write, and bit 2 = the privilege level was 3.
- R10: The fault-address register takes the faulting linear address when a fault is raised and holds its value at all other times.
- R11: Any failed walk returns phys_addr = all ones. A failed probe walk raises no fault and leaves the fault-address register unchanged.
- R12: `req_ready` is high only while idle, and requests presented during a walk are ignored. `done` is high for exactly one cycle per walk, and `fault` is asserted only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_base | input | 32 | Page directory base (low 12 bits ignored) |
| req_valid | input | 1 | Start a walk (taken when req_ready is high) |
| req_ready | output | 1 | Walker is idle |
| req_va | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| req_cpl | input | 2 | Current privilege level |
| req_ovr | input | 1 | Supervisor override |
| req_probe | input | 1 | Probe: report failure without faulting |
| wp_en | input | 1 | Write-protect applies at supervisor levels |
| large_en | input | 1 | Enable 4 MB pages |
| mem_req | output | 1 | One-cycle fetch request |
| mem_addr | output | 32 | Fetch byte address |
| mem_rvalid | input | 1 | Fetch response strobe |
| mem_rdata | input | 32 | Fetched entry |
| done | output | 1 | Walk complete pulse |
| fault | output | 1 | Fault raised (with done) |
| fault_code | output | 3 | Fault code |
| fault_addr | output | 32 | Latched faulting linear address |
| phys_addr | output | 32 | Translated address, all ones on failure |

## Verification
The bench aims at the cases where the two levels must be combined correctly. One such case is a directory entry that denies user access or writes while the table entry permits them. A walker that checked only the table entry would let that access through. Another is the large-page bit seen while large pages are disabled: a walker that ignored the enable would stop after one fetch with a wrong address. The bench also covers supervisor writes to read-only pages under every combination of write-protect and override, to catch an override that fails to suppress the write check. Failed probes must not disturb the fault-address register. Requests presented mid-walk must not restart or corrupt the walk in progress.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  localparam int ADDR_W   = 32;
  localparam int OFF_W    = 12;
  localparam int IDX_W    = 10;
  localparam int BIT_PRES = 0;
  localparam int BIT_WR   = 1;
  localparam int BIT_USER = 2;
  localparam int BIT_BIG  = 7;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PDE  = 2'd1,
    ST_PTE  = 2'd2,
    ST_DONE = 2'd3
  } walk_st_e;

  typedef struct packed {
    logic user;
    logic wr;
    logic pres;
  } perm_t;
endpackage

// File: rtl/pgwalk_addr_gen.sv
module pgwalk_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10
) (
  input  logic [ADDR_W-1:0] dir_base,
  input  logic [ADDR_W-1:0] va,
  input  logic [ADDR_W-1:0] pde,
  input  logic [ADDR_W-1:0] pte,
  output logic [ADDR_W-1:0] pde_addr,
  output logic [ADDR_W-1:0] pte_addr,
  output logic [ADDR_W-1:0] large_pa,
  output logic [ADDR_W-1:0] small_pa
);
  localparam int LG_OFF_W = OFF_W + IDX_W;
  localparam int FRAME_W  = ADDR_W - OFF_W;
  localparam int LFRAME_W = ADDR_W - LG_OFF_W;

  logic [ADDR_W-1:0] dir_idx_off;
  logic [ADDR_W-1:0] tbl_idx_off;

  // Entries are four bytes wide, so each index scales by four.
  assign dir_idx_off = ADDR_W'(va[ADDR_W-1:LG_OFF_W]) << 2;
  assign tbl_idx_off = ADDR_W'(va[LG_OFF_W-1:OFF_W]) << 2;

  assign pde_addr = {dir_base[ADDR_W-1:OFF_W], {OFF_W{1'b0}}} | dir_idx_off;
  assign pte_addr = {pde[ADDR_W-1:OFF_W], {OFF_W{1'b0}}} | tbl_idx_off;

  assign large_pa = {pde[ADDR_W-1 -: LFRAME_W], va[LG_OFF_W-1:0]};
  assign small_pa = {pte[ADDR_W-1 -: FRAME_W], va[OFF_W-1:0]};
endmodule

// File: rtl/pgwalk_perm_chk.sv
module pgwalk_perm_chk
  import pgwalk_pkg::*;
(
  input  perm_t perm,
  input  logic  is_write,
  input  logic  user_lvl,
  input  logic  ovr,
  input  logic  wp_en,
  output logic  deny
);
  logic user_deny;
  logic write_deny;

  assign user_deny  = user_lvl & ~perm.user & ~ovr;
  assign write_deny = is_write & ~perm.wr & ~ovr & (user_lvl | wp_en);
  assign deny       = user_deny | write_deny;
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int AW      = pgwalk_pkg::ADDR_W,
  parameter int PG_OFF  = pgwalk_pkg::OFF_W,
  parameter int PG_IDX  = pgwalk_pkg::IDX_W,
  parameter int BIG_BIT = pgwalk_pkg::BIT_BIG
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] dir_base,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_va,
  input  logic          req_write,
  input  logic [1:0]    req_cpl,
  input  logic          req_ovr,
  input  logic          req_probe,
  input  logic          wp_en,
  input  logic          large_en,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [AW-1:0] mem_rdata,
  output logic          done,
  output logic          fault,
  output logic [2:0]    fault_code,
  output logic [AW-1:0] fault_addr,
  output logic [AW-1:0] phys_addr
);
  localparam logic [1:0] USER_CPL = 2'd3;

  walk_st_e      st_q;
  logic [AW-1:0] va_q;
  logic          wr_q;
  logic          u3_q;
  logic          ovr_q;
  logic          probe_q;
  logic          wp_q;
  logic          big_q;
  perm_t         pde_perm_q;
  logic [AW-1:0] pde_q;

  logic [AW-1:0] pde_addr_w;
  logic [AW-1:0] pte_addr_w;
  logic [AW-1:0] large_pa_w;
  logic [AW-1:0] small_pa_w;
  logic [AW-1:0] pde_src;
  perm_t         ent_perm;
  perm_t         eff_perm;
  logic          deny_w;
  logic          ent_present;
  logic          big_hit;

  // Address formation, fed by the request address while idle and the
  // held address afterwards.
  assign pde_src = (st_q == ST_PDE) ? mem_rdata : pde_q;

  pgwalk_addr_gen #(
    .ADDR_W (AW),
    .OFF_W  (PG_OFF),
    .IDX_W  (PG_IDX)
  ) addr_i (
    .dir_base (dir_base),
    .va       ((st_q == ST_IDLE) ? req_va : va_q),
    .pde      (pde_src),
    .pte      (mem_rdata),
    .pde_addr (pde_addr_w),
    .pte_addr (pte_addr_w),
    .large_pa (large_pa_w),
    .small_pa (small_pa_w)
  );

  assign ent_perm.pres = mem_rdata[BIT_PRES];
  assign ent_perm.wr   = mem_rdata[BIT_WR];
  assign ent_perm.user = mem_rdata[BIT_USER];
  assign ent_present   = mem_rdata[BIT_PRES];
  assign big_hit       = big_q & mem_rdata[BIG_BIT];

  // The second level narrows the rights granted by the first.
  assign eff_perm = (st_q == ST_PTE) ? (pde_perm_q & ent_perm) : ent_perm;

  pgwalk_perm_chk perm_i (
    .perm     (eff_perm),
    .is_write (wr_q),
    .user_lvl (u3_q),
    .ovr      (ovr_q),
    .wp_en    (wp_q),
    .deny     (deny_w)
  );

  assign req_ready = (st_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      va_q       <= '0;
      wr_q       <= 1'b0;
      u3_q       <= 1'b0;
      ovr_q      <= 1'b0;
      probe_q    <= 1'b0;
      wp_q       <= 1'b0;
      big_q      <= 1'b0;
      pde_perm_q <= '0;
      pde_q      <= '0;
      mem_req    <= 1'b0;
      mem_addr   <= '0;
      done       <= 1'b0;
      fault      <= 1'b0;
      fault_code <= '0;
      fault_addr <= '0;
      phys_addr  <= '0;
    end else begin
      mem_req <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            va_q     <= req_va;
            wr_q     <= req_write;
            u3_q     <= (req_cpl == USER_CPL);
            ovr_q    <= req_ovr;
            probe_q  <= req_probe;
            wp_q     <= wp_en;
            big_q    <= large_en;
            mem_req  <= 1'b1;
            mem_addr <= pde_addr_w;
            st_q     <= ST_PDE;
          end
        end
        ST_PDE: begin
          if (mem_rvalid) begin
            pde_q      <= mem_rdata;
            pde_perm_q <= ent_perm;
            if (!ent_present || (big_hit && deny_w)) begin
              st_q      <= ST_DONE;
              done      <= 1'b1;
              phys_addr <= '1;
              if (!probe_q) begin
                fault      <= 1'b1;
                fault_addr <= va_q;
                fault_code <= {u3_q, wr_q, ent_present};
              end
            end else if (big_hit) begin
              st_q      <= ST_DONE;
              done      <= 1'b1;
              phys_addr <= large_pa_w;
            end else begin
              mem_req  <= 1'b1;
              mem_addr <= pte_addr_w;
              st_q     <= ST_PTE;
            end
          end
        end
        ST_PTE: begin
          if (mem_rvalid) begin
            st_q <= ST_DONE;
            done <= 1'b1;
            if (!ent_present || deny_w) begin
              phys_addr <= '1;
              if (!probe_q) begin
                fault      <= 1'b1;
                fault_addr <= va_q;
                fault_code <= {u3_q, wr_q, ent_present};
              end
            end else begin
              phys_addr <= small_pa_w;
            end
          end
        end
        default: begin
          done  <= 1'b0;
          fault <= 1'b0;
          st_q  <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          done,
  input logic          fault,
  input logic          req_ready,
  input logic          mem_req,
  input logic          probe_q,
  input logic [AW-1:0] fault_addr,
  input logic [AW-1:0] phys_addr
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done held"); // R12

  AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    fault |-> done) else $error("fault without done"); // R12

  AST_BUSY_WHILE_FETCH: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready) else $error("fetch while idle"); // R12

  AST_FADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !fault |-> $stable(fault_addr)) else $error("fault_addr moved"); // R10

  AST_PROBE_SILENT: assert property (@(posedge clk) disable iff (rst)
    (done && probe_q) |-> !fault) else $error("probe faulted"); // R11

  AST_FAULT_PA_ONES: assert property (@(posedge clk) disable iff (rst)
    fault |-> (phys_addr == '1)) else $error("fault with valid pa"); // R11
endmodule

bind pgwalk_top pgwalk_chk #(.AW(AW)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .done       (done),
  .fault      (fault),
  .req_ready  (req_ready),
  .mem_req    (mem_req),
  .probe_q    (probe_q),
  .fault_addr (fault_addr),
  .phys_addr  (phys_addr)
);

// File: tb/pgwalk_top_tb_top.sv
module pgwalk_top_tb_top;
  localparam logic [31:0] DIRB = 32'h0010_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_cpl = 2'd0;
  logic        req_ovr = 1'b0;
  logic        req_probe = 1'b0;
  logic        wp_en = 1'b0;
  logic        large_en = 1'b0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done;
  logic        fault;
  logic [2:0]  fault_code;
  logic [31:0] fault_addr;
  logic [31:0] phys_addr;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  pgwalk_top dut_i (
    .clk(clk), .rst(rst), .dir_base(DIRB),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_write(req_write), .req_cpl(req_cpl), .req_ovr(req_ovr),
    .req_probe(req_probe), .wp_en(wp_en), .large_en(large_en),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .done(done), .fault(fault),
    .fault_code(fault_code), .fault_addr(fault_addr), .phys_addr(phys_addr)
  );

  // Sparse memory model with variable response latency and a fetch log.
  logic [31:0] mem [logic [31:0]];
  logic [31:0] rd_log [0:4095];
  int          rd_total = 0;
  int          lat_cfg = 1;
  int          lat_cnt = 0;
  logic        pend = 1'b0;
  logic [31:0] pend_addr = '0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req) begin
      pend      <= 1'b1;
      pend_addr <= mem_addr;
      lat_cnt   <= lat_cfg;
      rd_log[rd_total] <= mem_addr;
      rd_total  <= rd_total + 1;
    end else if (pend) begin
      if (lat_cnt == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= rd(pend_addr);
        pend       <= 1'b0;
      end else begin
        lat_cnt <= lat_cnt - 1;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference walk computed from the requirements.
  function automatic void ref_walk(input logic [31:0] va, input logic wr, input logic [1:0] cpl,
      input logic ovr, input logic wp, input logic lg,
      output logic fail, output logic pres, output logic [31:0] pa,
      output int nrd, output logic [31:0] a0, output logic [31:0] a1);
    logic [31:0] pde, pte;
    logic [2:0]  pm;
    logic        u3;
    a0 = DIRB | ({22'b0, va[31:22]} << 2);
    a1 = '0;
    pde = rd(a0);
    nrd = 1;
    fail = 1'b0; pres = 1'b1; pa = '1; pm = '0;
    if (!pde[0]) begin
      fail = 1'b1; pres = 1'b0;
    end else if (lg && pde[7]) begin
      pm = pde[2:0];
      pa = {pde[31:22], va[21:0]};
    end else begin
      a1 = {pde[31:12], 12'b0} | ({22'b0, va[21:12]} << 2);
      pte = rd(a1);
      nrd = 2;
      if (!pte[0]) begin
        fail = 1'b1; pres = 1'b0;
      end else begin
        pm = pde[2:0] & pte[2:0];
        pa = {pte[31:12], va[11:0]};
      end
    end
    if (!fail) begin
      u3 = (cpl == 2'd3);
      if ((u3 && !pm[2] && !ovr) || (wr && !pm[1] && !ovr && (u3 || wp))) fail = 1'b1;
    end
    if (fail) pa = '1;
  endfunction

  task automatic walk(input string tag, input logic [31:0] va, input logic wr, input logic [1:0] cpl,
      input logic ovr, input logic wp, input logic lg, input logic probe, input bit busy_poke);
    logic fail, pres;
    logic [31:0] pa, a0, a1, old_fa;
    int nrd, start, w;
    ref_walk(va, wr, cpl, ovr, wp, lg, fail, pres, pa, nrd, a0, a1);
    w = 0;
    while (!req_ready && w < 100) begin @(negedge clk); w++; end
    old_fa = fault_addr;
    start = rd_total;
    req_va = va; req_write = wr; req_cpl = cpl; req_ovr = ovr;
    wp_en = wp; large_en = lg; req_probe = probe; req_valid = 1'b1;
    @(negedge clk);
    if (busy_poke) begin
      check({tag, " R12 ready low while busy"}, {31'b0, req_ready}, 32'd0);
      req_va = ~va; req_write = ~wr; req_probe = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
    req_valid = 1'b0;
    w = 0;
    while (!done && w < 200) begin @(negedge clk); w++; end
    if (!done) begin
      errors++; checks++;
      $display("FAIL %s R12 walk never finished actual=0 expected=1", tag);
      return;
    end
    check({tag, " R11/R12 fault flag"}, {31'b0, fault}, {31'b0, fail & ~probe});
    check({tag, " R3/R5/R11 phys_addr"}, phys_addr, pa);
    if (fail && !probe)
      check({tag, " R9 fault_code"}, {29'b0, fault_code}, {29'b0, (cpl == 2'd3), wr, pres});
    check({tag, " R10/R11 fault_addr"}, fault_addr, (fail && !probe) ? va : old_fa);
    check({tag, " R2/R3 fetch count"}, rd_total - start, nrd);
    check({tag, " R1 first fetch"}, rd_log[start], a0);
    if (nrd == 2) check({tag, " R4 second fetch"}, rd_log[start+1], a1);
    @(negedge clk);
    check({tag, " R12 done one cycle"}, {31'b0, done}, 32'd0);
  endtask

  function automatic logic [31:0] pde_at(input logic [31:0] va);
    return DIRB | ({22'b0, va[31:22]} << 2);
  endfunction

  function automatic logic [31:0] tframe(input int i);
    return 32'h0040_0000 + 32'(i) * 32'h1000;
  endfunction

  task automatic map(input logic [31:0] va, input logic [31:0] pde, input logic [31:0] pte);
    mem[pde_at(va)] = pde;
    mem[{pde[31:12], 12'b0} | ({22'b0, va[21:12]} << 2)] = pte;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] va;
    void'($urandom(32'h1f2e3d4c));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R12 reset ready", {31'b0, req_ready}, 32'd1);
    check("R12 reset done", {31'b0, done}, 32'd0);
    check("R10 reset fault_addr", fault_addr, 32'd0);
    check("R12 reset mem_req", {31'b0, mem_req}, 32'd0);

    // R3 large page hit, then the same entry with large pages disabled.
    va = 32'h0123_4567;
    map(va, 32'h0C00_0087 | tframe(4), 32'h0ABC_D007);
    walk("large", va, 1'b1, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 0);
    walk("large_off", va, 1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 0);
    // R2 directory entry absent.
    va = 32'h0040_1000;
    mem[pde_at(va)] = 32'h0000_0006;
    walk("pde_absent", va, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    // R6 table entry absent.
    va = 32'h0080_2ABC;
    map(va, tframe(2) | 32'h7, 32'h1234_5006);
    walk("pte_absent", va, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    // R6/R7 directory denies user though table allows.
    va = 32'h00C0_3123;
    map(va, tframe(3) | 32'h3, 32'h5555_5007);
    walk("and_user", va, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    walk("ovr_user", va, 1'b0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 0);
    walk("sup_user_ok", va, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    // R8 read-only page under write-protect / override combinations.
    va = 32'h0100_4FF0;
    map(va, tframe(5) | 32'h7, 32'h6666_6005);
    walk("ro_wp0", va, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    walk("ro_wp1", va, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 0);
    walk("ro_wp1_ovr", va, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 0);
    walk("ro_user_ovr", va, 1'b1, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 0);
    walk("ro_user", va, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    // R11 failed probe leaves fault state alone.
    walk("probe_fail", va, 1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 0);
    // R12 requests during a walk are ignored.
    lat_cfg = 3;
    walk("busy", va, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1);

    for (int n = 0; n < 300; n++) begin
      int pdi, pti, off;
      logic [31:0] pde, pte;
      pdi = int'($urandom % 8);
      pti = int'($urandom % 1024);
      off = int'($urandom % 4096);
      va  = {pdi[9:0], pti[9:0], off[11:0]};
      pde = tframe(pdi) | {24'b0, $urandom(), 7'b0} & 32'h80 | 32'($urandom % 8);
      if ($urandom % 8 != 0) pde[0] = 1'b1;
      pte = {$urandom(), 12'b0} & 32'hFFFF_F000 | 32'($urandom % 8);
      if ($urandom % 4 != 0) pte[0] = 1'b1;
      map(va, pde, pte);
      lat_cfg = int'($urandom % 4);
      walk("rand", va, 1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom % 4 == 0), 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule